// File: doc/BRIEF.md
# Receive Descriptor Chain Engine

This engine stores incoming messages in memory buffers. Software supplies the buffers. For each receive queue, software builds a linked chain of four-word descriptors in memory and then writes the address of the first descriptor into that queue's head register. That write starts the queue.

When a message arrives on the byte stream, the engine reads the descriptor at the head of the addressed queue. If the hardware owns that descriptor, the engine fills its buffer with payload bytes. It then writes the descriptor's flags word back with ownership cleared and posts the descriptor's address to the queue's completion register. Each completion produces a one-cycle event for the separate interrupt block. The engine then moves on along the chain, and a long message spreads over several descriptors.

When a chain runs out, the engine marks end-of-queue in the last descriptor it used. The queue then halts, and any message sent to it is accepted and discarded until software writes a new head pointer. The engine serves one message at a time. The message stream uses valid/ready handshaking: a byte transfers on a clock edge where both `msg_valid` and `msg_ready` are high. The sender must hold the byte, the queue number and `msg_last` steady while `msg_valid` is high and `msg_ready` is low. The engine holds `msg_ready` low while it reads descriptors and writes back flags.

Top module: `rxq_engine`

## Requirements
- R1: Up to NQ (default 16) queues each have a head register. A register write with `reg_addr[0]`=0 loads that queue's head from `reg_wdata`, starts the queue, and reads back on `reg_rdata`. After reset every head and completion register reads 0.
- R2: A message is stored starting at the descriptor named by the queue's head. The engine reaches each further descriptor through word 0 (next pointer) of the current one. After a message, the head register holds the next unused descriptor.
- R3: A descriptor is used only when bit 0 (ownership) of its word 3 is 1. If the head descriptor is not owned, nothing is written, no event occurs, the head is unchanged and the queue halts. Every written-back flags word has bit 0 cleared.
- R4: After each descriptor is filled, its flags word is written first. The completion register of the queue (read with `reg_addr[0]`=1) then takes the descriptor's address.
- R5: A descriptor's buffer (word 1 = word address) takes min(word 2, 256) payload bytes, with word 2 = 0 meaning 256. Payload byte i of that buffer lands in word base+i/4, byte lane i%4, and each payload write enables exactly one lane.
- R6: Each completion raises `cmp_valid` for exactly one cycle, with `cmp_queue` set to the queue.
- R7: The flags word is written back as bit 1 end-of-queue, bit 2 start-of-packet (first descriptor of the message), bit 3 end-of-packet (descriptor holding the final stored byte), and bits 31:4 preserved.
- R8: If the next pointer is 0, or the next descriptor's ownership bit is 0, the last used descriptor gets end-of-queue. The head then reads 0, and messages to that queue, or to a queue never started, are accepted and discarded until the head is rewritten.
- R9: At most 4096 bytes of one message are stored. The descriptor holding byte 4096 gets end-of-packet, and the remaining bytes are discarded.
- R10: `msg_ready` is low in the cycle a message is first presented and during the four descriptor reads. A payload write occurs only on a handshake beat.
- R11: A register write with `reg_addr[0]`=1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | QW+1 | {queue, select}; select 0 = head, 1 = completion |
| reg_wdata | input | AW | Head pointer write data |
| reg_rdata | output | AW | Selected register contents |
| msg_valid | input | 1 | Message byte valid |
| msg_ready | output | 1 | Engine accepts a byte |
| msg_q | input | QW | Queue of the message |
| msg_data | input | 8 | Payload byte |
| msg_last | input | 1 | Final byte of the message |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| cmp_valid | output | 1 | Completion event |
| cmp_queue | output | QW | Queue of the completion event |

## Verification
The assertions check rules that hold on every cycle:
- ownership is clear in every flags write-back;
- every payload write enables exactly one lane and falls on a handshake beat;
- no buffer takes more than 256 bytes between flag write-backs;
- each completion event lasts one cycle and directly follows a flag write-back.

Other behaviour shows only in the bench's scenarios. These include where bytes land, how descriptors chain, and the exact head and completion values. They also include the sizing rules (zero-length and oversized buffers, the 4096-byte cut), the end-of-queue halt and its release by a new head write, and the exact number of cycles `msg_ready` stays low.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_RDW,
    S_FILL, S_CLOSE, S_PEEK, S_WBF, S_CPW, S_DROP
  } eng_st_e;

  // descriptor word offsets
  localparam int OFS_NEXT = 0;
  localparam int OFS_BUF  = 1;
  localparam int OFS_LEN  = 2;
  localparam int OFS_FLG  = 3;

  // flag bit positions
  localparam int FB_OWN = 0;
  localparam int FB_EOQ = 1;
  localparam int FB_SOP = 2;
  localparam int FB_EOP = 3;
endpackage

// File: rtl/rxq_qregs.sv
module rxq_qregs #(
  parameter int NQ = 16,
  parameter int AW = 12,
  localparam int QW = $clog2(NQ)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sw_we,
  input  logic [QW-1:0]          sw_q,
  input  logic [AW-1:0]          sw_head,
  input  logic [QW-1:0]          eng_q,
  input  logic                   eng_head_we,
  input  logic [AW-1:0]          eng_head,
  input  logic                   eng_stop,
  input  logic                   eng_cp_we,
  input  logic [AW-1:0]          eng_cp,
  output logic [NQ-1:0][AW-1:0]  head_o,
  output logic [NQ-1:0][AW-1:0]  cp_o,
  output logic [NQ-1:0]          active_o
);
  for (genvar g = 0; g < NQ; g++) begin : g_q
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        head_o[g]   <= '0;
        cp_o[g]     <= '0;
        active_o[g] <= 1'b0;
      end else begin
        // a software head write wins over the engine in the same cycle
        if (sw_we && sw_q == QW'(g)) begin
          head_o[g]   <= sw_head;
          active_o[g] <= 1'b1;
        end else if (eng_q == QW'(g)) begin
          if (eng_head_we) head_o[g] <= eng_head;
          if (eng_stop)    active_o[g] <= 1'b0;
        end
        if (eng_cp_we && eng_q == QW'(g)) cp_o[g] <= eng_cp;
      end
    end
  end
endmodule

// File: rtl/rxq_core.sv
module rxq_core
  import rxq_pkg::*;
#(
  parameter int NQ      = 16,
  parameter int AW      = 12,
  parameter int SEG_MAX = 256,
  parameter int MSG_MAX = 4096,
  localparam int QW = $clog2(NQ),
  localparam int CW = $clog2(SEG_MAX) + 1,
  localparam int TW = $clog2(MSG_MAX) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_valid,
  output logic          msg_ready,
  input  logic [QW-1:0] msg_q,
  input  logic [7:0]    msg_data,
  input  logic          msg_last,
  input  logic [AW-1:0] q_head_i,
  input  logic          q_active_i,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [QW-1:0] eng_q,
  output logic          eng_head_we,
  output logic [AW-1:0] eng_head,
  output logic          eng_stop,
  output logic          eng_cp_we,
  output logic [AW-1:0] eng_cp,
  output logic          cmp_valid,
  output logic [QW-1:0] cmp_queue
);
  eng_st_e       st;
  logic [QW-1:0] q_r;
  logic [AW-1:0] cur, nxt, bufp;
  logic [CW-1:0] lim, cnt;
  logic [TW-1:0] tot;
  logic [31:0]   flg;
  logic          sop_r, eop_r, eoq_r, trunc_r;

  function automatic logic [CW-1:0] lim_dec(input logic [31:0] w);
    if (w == 32'd0 || w > 32'(SEG_MAX)) return CW'(SEG_MAX);
    return w[CW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      q_r <= '0; cur <= '0; nxt <= '0; bufp <= '0;
      lim <= '0; cnt <= '0; tot <= '0; flg <= '0;
      sop_r <= 1'b0; eop_r <= 1'b0; eoq_r <= 1'b0; trunc_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (msg_valid) begin
          q_r <= msg_q;
          cur <= q_head_i;
          sop_r <= 1'b1; eop_r <= 1'b0; trunc_r <= 1'b0;
          tot <= '0;
          st <= q_active_i ? S_RD0 : S_DROP;
        end
        S_RD0: st <= S_RD1;
        S_RD1: begin nxt  <= mem_rdata[AW-1:0]; st <= S_RD2; end
        S_RD2: begin bufp <= mem_rdata[AW-1:0]; st <= S_RD3; end
        S_RD3: begin lim  <= lim_dec(mem_rdata); st <= S_RDW; end
        S_RDW: begin
          flg <= mem_rdata;
          cnt <= '0;
          eoq_r <= 1'b0;
          st <= mem_rdata[FB_OWN] ? S_FILL : S_DROP;
        end
        S_FILL: if (msg_valid) begin
          cnt <= cnt + 1'b1;
          tot <= tot + 1'b1;
          if (msg_last) begin
            eop_r <= 1'b1; st <= S_CLOSE;
          end else if (tot == TW'(MSG_MAX - 1)) begin
            eop_r <= 1'b1; trunc_r <= 1'b1; st <= S_CLOSE;
          end else if (cnt == lim - 1'b1) begin
            st <= S_CLOSE;
          end
        end
        S_CLOSE: if (nxt == '0) begin
          eoq_r <= 1'b1; st <= S_WBF;
        end else begin
          st <= S_PEEK;
        end
        S_PEEK: begin eoq_r <= !mem_rdata[FB_OWN]; st <= S_WBF; end
        S_WBF:  st <= S_CPW;
        S_CPW: begin
          sop_r <= 1'b0;
          cur <= nxt;
          if (eop_r)      st <= trunc_r ? S_DROP : S_IDLE;
          else if (eoq_r) st <= S_DROP;
          else            st <= S_RD0;
        end
        S_DROP: if (msg_valid && msg_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign msg_ready = (st == S_FILL) || (st == S_DROP);

  always_comb begin
    mem_req = 1'b0;
    mem_we = 1'b0;
    mem_addr = cur;
    mem_be = 4'h0;
    mem_wdata = '0;
    case (st)
      S_RD0: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_NEXT); end
      S_RD1: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_BUF); end
      S_RD2: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_LEN); end
      S_RD3: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_FLG); end
      S_FILL: begin
        mem_req = msg_valid;
        mem_we = 1'b1;
        mem_addr = bufp + AW'(cnt[CW-1:2]);
        mem_be = 4'b0001 << cnt[1:0];
        mem_wdata = {4{msg_data}};
      end
      S_CLOSE: begin mem_req = (nxt != '0); mem_addr = nxt + AW'(OFS_FLG); end
      S_WBF: begin
        mem_req = 1'b1;
        mem_we = 1'b1;
        mem_addr = cur + AW'(OFS_FLG);
        mem_be = 4'hF;
        mem_wdata = {flg[31:4], eop_r, sop_r, eoq_r, 1'b0};
      end
      default: ;
    endcase
  end

  assign eng_q       = q_r;
  assign eng_cp_we   = (st == S_CPW);
  assign eng_cp      = cur;
  assign eng_head_we = (st == S_CPW);
  assign eng_head    = eoq_r ? '0 : nxt;
  assign eng_stop    = (st == S_CPW && eoq_r) || (st == S_RDW && !mem_rdata[FB_OWN]);
  assign cmp_valid   = (st == S_CPW);
  assign cmp_queue   = q_r;
endmodule

// File: rtl/rxq_engine.sv
module rxq_engine #(
  parameter int NQ      = 16,
  parameter int AW      = 12,
  parameter int SEG_MAX = 256,
  parameter int MSG_MAX = 4096,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [QW:0]   reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          msg_valid,
  output logic          msg_ready,
  input  logic [QW-1:0] msg_q,
  input  logic [7:0]    msg_data,
  input  logic          msg_last,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          cmp_valid,
  output logic [QW-1:0] cmp_queue
);
  logic [NQ-1:0][AW-1:0] head_a, cp_a;
  logic [NQ-1:0]         active_a;
  logic [QW-1:0]         eng_q;
  logic                  eng_head_we, eng_stop, eng_cp_we;
  logic [AW-1:0]         eng_head, eng_cp;
  logic [QW-1:0]         rq;

  assign rq = reg_addr[QW:1];
  assign reg_rdata = reg_addr[0] ? cp_a[rq] : head_a[rq];

  rxq_qregs #(.NQ(NQ), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_we(reg_we && !reg_addr[0]), .sw_q(rq), .sw_head(reg_wdata),
    .eng_q(eng_q), .eng_head_we(eng_head_we), .eng_head(eng_head),
    .eng_stop(eng_stop), .eng_cp_we(eng_cp_we), .eng_cp(eng_cp),
    .head_o(head_a), .cp_o(cp_a), .active_o(active_a)
  );

  rxq_core #(.NQ(NQ), .AW(AW), .SEG_MAX(SEG_MAX), .MSG_MAX(MSG_MAX)) u_core (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_q(msg_q),
    .msg_data(msg_data), .msg_last(msg_last),
    .q_head_i(head_a[msg_q]), .q_active_i(active_a[msg_q]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .eng_q(eng_q), .eng_head_we(eng_head_we), .eng_head(eng_head),
    .eng_stop(eng_stop), .eng_cp_we(eng_cp_we), .eng_cp(eng_cp),
    .cmp_valid(cmp_valid), .cmp_queue(cmp_queue)
  );
endmodule

// File: rtl/rxq_engine_chk.sv
module rxq_engine_chk #(
  parameter int SEG_MAX = 256,
  localparam int SW = $clog2(SEG_MAX) + 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       mem_we,
  input logic [3:0] mem_be,
  input logic       wb_own,
  input logic       cmp_valid,
  input logic       msg_valid,
  input logic       msg_ready
);
  logic [SW-1:0] seg_cnt;
  logic          wr_full, wr_lane;

  assign wr_full = mem_req && mem_we && (mem_be == 4'hF);
  assign wr_lane = mem_req && mem_we && (mem_be != 4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n)       seg_cnt <= '0;
    else if (wr_full) seg_cnt <= '0;
    else if (wr_lane) seg_cnt <= seg_cnt + 1'b1;
  end

  p_own_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> !wb_own);

  p_flags_before_cp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(wr_full));

  p_single_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane |-> $countones(mem_be) == 1);

  p_seg_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_cnt <= SW'(SEG_MAX));

  p_cmp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> !cmp_valid);

  p_write_on_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane |-> (msg_valid && msg_ready));
endmodule

bind rxq_engine rxq_engine_chk #(.SEG_MAX(SEG_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_be(mem_be), .wb_own(mem_wdata[0]), .cmp_valid(cmp_valid),
  .msg_valid(msg_valid), .msg_ready(msg_ready)
);

// File: tb/tb_rxq_engine.sv
module tb_rxq_engine;
  localparam int PERIOD = 10;
  localparam int NQ = 16;
  localparam int AW = 11;
  localparam int QW = 4;

  typedef struct packed {
    logic [3:0]  q;
    logic [15:0] len;
    logic [15:0] blen;
    logic [7:0]  nd;
    logic [7:0]  seed;
  } vec_t;

  // queue, message length, buffer length field, chain length, byte seed
  localparam vec_t VECS [7] = '{
    '{4'd0,  16'd10,   16'd64,   8'd2,  8'd3},
    '{4'd3,  16'd200,  16'd64,   8'd4,  8'd17},
    '{4'd15, 16'd300,  16'd0,    8'd3,  8'd40},
    '{4'd7,  16'd600,  16'd256,  8'd2,  8'd91},
    '{4'd9,  16'd4100, 16'd1000, 8'd17, 8'd5},
    '{4'd1,  16'd1,    16'd4,    8'd1,  8'd200},
    '{4'd2,  16'd8,    16'd8,    8'd1,  8'd77}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [QW:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic msg_valid = 1'b0, msg_last = 1'b0;
  logic msg_ready;
  logic [QW-1:0] msg_q = '0;
  logic [7:0] msg_data = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic cmp_valid;
  logic [QW-1:0] cmp_queue;

  logic tb_we = 1'b0;
  logic [AW-1:0] tb_a = '0;
  logic [31:0] tb_d = '0;
  logic [31:0] mem [2048];
  int wr_cnt = 0, ev_cnt = 0, badq = 0;
  logic [QW-1:0] exp_q = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rxq_engine #(.NQ(NQ), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_q(msg_q),
    .msg_data(msg_data), .msg_last(msg_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cmp_valid(cmp_valid), .cmp_queue(cmp_queue)
  );

  // memory model: one-cycle read latency, byte-lane writes
  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
    if (rst_n && cmp_valid) begin
      ev_cnt <= ev_cnt + 1;
      if (cmp_queue != exp_q) badq <= badq + 1;
    end
  end

  function automatic logic [AW-1:0] daddr(input int k);
    return AW'(4 + 4*k);
  endfunction
  function automatic logic [AW-1:0] baddr(input int k);
    return AW'(256 + 64*k);
  endfunction
  function automatic logic [7:0] pat(input int j, input int seed);
    return 8'(j*7 + seed);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mwr(input logic [AW-1:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic regw(input int q, input bit sel, input logic [AW-1:0] d);
    reg_we = 1'b1; reg_addr = {QW'(q), sel}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic regr(input int q, input bit sel, output logic [AW-1:0] d);
    reg_addr = {QW'(q), sel};
    #1 d = reg_rdata;
  endtask

  task automatic send(input int q, input int len, input int seed);
    for (int j = 0; j < len; j++) begin
      msg_valid = 1'b1; msg_q = QW'(q); msg_data = pat(j, seed);
      msg_last = (j == len - 1);
      while (!msg_ready) @(negedge clk);
      @(negedge clk);
    end
    msg_valid = 1'b0; msg_last = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic setup_desc(input int k, input logic [AW-1:0] nx, input int bk,
                            input int blen, input logic [31:0] flags);
    mwr(daddr(k) + 0, 32'(nx));
    mwr(daddr(k) + 1, 32'(baddr(bk)));
    mwr(daddr(k) + 2, 32'(blen));
    mwr(daddr(k) + 3, flags);
  endtask

  task automatic run_vec(input vec_t v);
    int q, len, nd, seed, eff, lcap, segs, used, stored, ev0, bq0, errs;
    logic [AW-1:0] rv;
    logic [31:0] expf;
    q = int'(v.q); len = int'(v.len); nd = int'(v.nd); seed = int'(v.seed);
    for (int k = 0; k < nd; k++)
      setup_desc(k, (k < nd - 1) ? daddr(k + 1) : '0, k, int'(v.blen), 32'h1);
    exp_q = v.q;
    regw(q, 1'b0, daddr(0));
    ev0 = ev_cnt; bq0 = badq;
    send(q, len, seed);
    eff  = (v.blen == 0 || v.blen > 256) ? 256 : int'(v.blen);
    lcap = (len > 4096) ? 4096 : len;
    segs = (lcap + eff - 1) / eff;
    used = (segs < nd) ? segs : nd;
    stored = (lcap < used*eff) ? lcap : used*eff;
    chk("R6", "event count", 32'(ev_cnt - ev0), 32'(used));
    chk("R6", "event queue", 32'(badq - bq0), 32'd0);
    for (int k = 0; k < nd; k++) begin
      if (k < used)
        expf = {28'd0, (k == segs - 1), (k == 0), (k == used - 1 && used == nd), 1'b0};
      else
        expf = 32'h1;
      chk("R7", "flags word", mem[daddr(k) + 3], expf);
    end
    regr(q, 1'b1, rv);
    chk("R4", "completion reg", 32'(rv), 32'(daddr(used - 1)));
    regr(q, 1'b0, rv);
    chk("R2", "head after msg", 32'(rv), (used == nd) ? 32'd0 : 32'(daddr(used)));
    errs = 0;
    for (int j = 0; j < stored; j++) begin
      int k, o;
      k = j / eff; o = j % eff;
      if (mem[baddr(k) + AW'(o/4)][8*(o%4) +: 8] !== pat(j, seed)) errs++;
    end
    chk((len > 4096) ? "R9" : "R5", "payload byte errors", 32'(errs), 32'd0);
  endtask

  initial begin
    logic [AW-1:0] rv;
    int wc0, ev0, lowc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    regr(0, 1'b0, rv); chk("R1", "head after reset", 32'(rv), 32'd0);
    regr(0, 1'b1, rv); chk("R1", "cp after reset", 32'(rv), 32'd0);
    chk("R10", "ready after reset", 32'(msg_ready), 32'd0);
    chk("R6", "event after reset", 32'(cmp_valid), 32'd0);
    regw(12, 1'b0, 11'h123);
    regr(12, 1'b0, rv); chk("R1", "head readback", 32'(rv), 32'h123);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R8: never-started queue drops the message
    wc0 = wr_cnt; ev0 = ev_cnt;
    send(5, 4, 9);
    chk("R8", "writes to idle queue", 32'(wr_cnt - wc0), 32'd0);
    chk("R8", "events idle queue", 32'(ev_cnt - ev0), 32'd0);

    // R3: head descriptor not owned
    exp_q = 4'd4;
    setup_desc(20, '0, 18, 16, 32'h0);
    regw(4, 1'b0, daddr(20));
    wc0 = wr_cnt; ev0 = ev_cnt;
    send(4, 4, 11);
    chk("R3", "writes unowned", 32'(wr_cnt - wc0), 32'd0);
    chk("R3", "events unowned", 32'(ev_cnt - ev0), 32'd0);
    chk("R3", "flags unowned", mem[daddr(20) + 3], 32'h0);
    regr(4, 1'b0, rv); chk("R3", "head unowned", 32'(rv), 32'(daddr(20)));
    mwr(daddr(20) + 3, 32'h1);
    send(4, 4, 12);
    chk("R8", "halted queue writes", 32'(wr_cnt - wc0), 32'd0);
    regw(4, 1'b0, daddr(20));
    send(4, 4, 13);
    chk("R3", "restart events", 32'(ev_cnt - ev0), 32'd1);
    chk("R3", "restart flags", mem[daddr(20) + 3], 32'hE);
    chk("R5", "restart byte", 32'(mem[baddr(18)][31:24]), 32'(pat(3, 13)));

    // R8: next descriptor not owned
    exp_q = 4'd6;
    setup_desc(21, daddr(22), 19, 8, 32'h1);
    setup_desc(22, '0, 20, 8, 32'h0);
    regw(6, 1'b0, daddr(21));
    send(6, 8, 33);
    chk("R8", "eoq on unowned next", mem[daddr(21) + 3], 32'hE);
    chk("R8", "next untouched", mem[daddr(22) + 3], 32'h0);
    regr(6, 1'b0, rv); chk("R8", "head zero", 32'(rv), 32'd0);

    // R11: write to completion select ignored
    regw(6, 1'b1, 11'h055);
    regr(6, 1'b1, rv); chk("R11", "cp unchanged", 32'(rv), 32'(daddr(21)));
    regr(6, 1'b0, rv); chk("R11", "head unchanged", 32'(rv), 32'd0);

    // R10: ready low through descriptor fetch
    exp_q = 4'd10;
    setup_desc(23, '0, 21, 4, 32'h1);
    regw(10, 1'b0, daddr(23));
    msg_valid = 1'b1; msg_q = 4'd10; msg_data = pat(0, 1); msg_last = 1'b0;
    lowc = 0;
    while (!msg_ready && lowc < 20) begin lowc++; @(negedge clk); end
    chk("R10", "ready-low cycles", 32'(lowc), 32'd6);
    send(10, 2, 1);
    chk("R10", "short msg flags", mem[daddr(23) + 3], 32'hE);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule